// File: doc/BRIEF.md
# Burst Read Wait-State Controller

This block produces the device-side timing of a synchronous burst read from a memory that is 16 bits wide. On a clock edge where the active-low address strobe is asserted, it captures a start address and a programmed wait-state count. It then counts out the initial latency. The latency is the programmed count plus one clock when the start address is odd, plus one more clock when the second word of the burst would cross an aligned block boundary. When the latency has run out and output enable is low, the ready flag rises together with the first data word. After that, one word is presented per clock at consecutive addresses.

The data words come from a small computed array, so no storage is needed. Output enable gates the bus completely. While it is high, ready stays low and the bus shows a fixed idle word. Raising it after words have streamed ends the burst. A new address strobe restarts the sequence at any time.

Top module: `burst_wait_ctrl`

## Requirements
- R1: After reset, with no address strobe, `rdy` is 0 and `dq` equals the idle word 16'h0000.
- R2: On a rising clock edge with `adv_n` = 0, the controller captures `addr_in` and `wait_cfg`. For an even start address that is not the last word of its 16-word block, `rdy` first reads 1 in the clock period that follows the W-th rising edge after the capture edge, where W = `wait_cfg`. When W = 0, this is the period right after the capture edge.
- R3: An odd start address (address bit 0 = 1) adds exactly one clock to the latency in R2.
- R4: A start address whose low four bits are 4'hF (the last word of a 16-word block, so the burst crosses the boundary on its first step) adds one further clock. Such an address is odd, so its total latency is W + 2. A start offset of 4'hE adds nothing.
- R5: While `rdy` is 1, each rising edge advances the presented address by one, wrapping modulo 256, so consecutive periods show consecutive words.
- R6: The word at address a is x ^ (x << 8) ^ 16'hC3A5, where x is a zero-extended to 16 bits. The first word shown is the word at the start address.
- R7: While `oe_n` = 1, `rdy` is 0 and `dq` is 16'h0000.
- R8: When `oe_n` is 1 at a rising edge after at least one word has been delivered, the burst ends. `rdy` then stays 0 after `oe_n` returns low, until the next address strobe.
- R9: `oe_n` high during the latency does not pause the count. If `oe_n` falls after the latency has run out, `rdy` rises in that same period with the start-address word. Every rise of `rdy` happens while `oe_n` is 0.
- R10: An address strobe during a burst restarts it: `rdy` drops, and the new latency and address apply from that capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n | input | 1 | Active-low address valid strobe |
| addr_in | input | 8 | Burst start address |
| oe_n | input | 1 | Active-low output enable |
| wait_cfg | input | 4 | Programmed wait-state count |
| rdy | output | 1 | High while a valid burst word is on `dq` |
| dq | output | 16 | Burst data word, idle value when not ready |

## Verification
A wrong latency count shows as `rdy` rising one or more periods early or late. Every burst checks `rdy` in each period from the capture edge onward, so a miscount is caught in the period it happens. A wrong address register shows on `dq` in the first streamed word, or in the first word after a step or a wrap, because each word is a distinct function of its address. A stale burst state after output enable rises shows as `rdy` reappearing the moment `oe_n` returns low, without a new strobe.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
   typedef enum logic [1:0] {
      BR_IDLE   = 2'd0,
      BR_WAIT   = 2'd1,
      BR_STREAM = 2'd2
   } br_state_t;
endpackage

// File: rtl/burst_lat_calc.sv
module burst_lat_calc #(
   parameter int WAIT_W      = 4,
   parameter int BOUND_LOG2  = 4,
   parameter int LAT_W       = WAIT_W + 1,
   parameter bit ODD_EXTRA   = 1'b1,
   parameter bit CROSS_EXTRA = 1'b1
) (
   input  logic [BOUND_LOG2-1:0] offset,
   input  logic [WAIT_W-1:0]     wait_cfg,
   output logic [LAT_W-1:0]      lat
);
   logic odd_add;
   logic cross_add;

   if (LAT_W < WAIT_W + 1) begin : g_bad_lat
      $error("LAT_W must hold wait_cfg plus two");
   end

   if (ODD_EXTRA) begin : g_odd
      assign odd_add = offset[0];
   end else begin : g_no_odd
      assign odd_add = 1'b0;
   end

   if (CROSS_EXTRA) begin : g_cross
      assign cross_add = &offset;
   end else begin : g_no_cross
      assign cross_add = 1'b0;
   end

   assign lat = LAT_W'(wait_cfg) + LAT_W'(odd_add) + LAT_W'(cross_add);

   always_comb begin
      AST_LAT_BOUNDS: assert (lat - LAT_W'(wait_cfg) <= LAT_W'(2)); // R4
   end
endmodule

// File: rtl/burst_wait_timer.sv
module burst_wait_timer
   import burst_rd_pkg::*;
#(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] lat,
   input  logic             oe_n,
   output logic             rdy
);
   br_state_t        st;
   logic [LAT_W-1:0] cnt;

   assign rdy = !oe_n && ((st == BR_WAIT && cnt == '0) || st == BR_STREAM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= BR_IDLE;
         cnt <= '0;
      end else if (load) begin
         st  <= BR_WAIT;
         cnt <= lat;
      end else begin
         case (st)
            BR_WAIT: begin
               if (cnt != '0)
                  cnt <= cnt - LAT_W'(1);
               else if (!oe_n)
                  st <= BR_STREAM;
            end
            BR_STREAM: begin
               if (oe_n)
                  st <= BR_IDLE;
            end
            default: st <= BR_IDLE;
         endcase
      end
   end

   AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BR_WAIT && cnt != '0 && !load) |=> (cnt == $past(cnt) - LAT_W'(1))); // R2
   AST_LOAD_HOLDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      (load && lat != '0) |=> !rdy); // R10
   AST_STREAM_END: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BR_STREAM && oe_n && !load) |=> !rdy); // R8
endmodule

// File: rtl/burst_word_src.sv
module burst_word_src #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 16,
   parameter logic [DATA_W-1:0] SEED      = 16'hC3A5,
   parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              step,
   output logic [DATA_W-1:0] dq
);
   logic [ADDR_W-1:0] cur;
   logic [DATA_W-1:0] a_ext;
   logic [DATA_W-1:0] word;

   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("ADDR_W must not exceed DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (load)
         cur <= start_addr;
      else if (step)
         cur <= cur + ADDR_W'(1);
   end

   always_comb begin
      a_ext = DATA_W'(cur);
      word  = a_ext ^ (a_ext << 8) ^ SEED;
   end

   assign dq = step ? word : IDLE_WORD;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur == $past(cur) + ADDR_W'(1))); // R5
   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur == $past(start_addr))); // R2
endmodule

// File: rtl/burst_wait_ctrl.sv
module burst_wait_ctrl #(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 16,
   parameter int                WAIT_W      = 4,
   parameter int                BOUND_LOG2  = 4,
   parameter bit                ODD_EXTRA   = 1'b1,
   parameter bit                CROSS_EXTRA = 1'b1,
   parameter logic [DATA_W-1:0] SEED        = 16'hC3A5,
   parameter logic [DATA_W-1:0] IDLE_WORD   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              oe_n,
   input  logic [WAIT_W-1:0] wait_cfg,
   output logic              rdy,
   output logic [DATA_W-1:0] dq
);
   localparam int LAT_W = WAIT_W + 1;

   if (BOUND_LOG2 < 1 || BOUND_LOG2 > ADDR_W) begin : g_bad_bound
      $error("BOUND_LOG2 must lie in 1..ADDR_W");
   end

   logic             load;
   logic [LAT_W-1:0] lat;

   assign load = !adv_n;

   burst_lat_calc #(
      .WAIT_W(WAIT_W), .BOUND_LOG2(BOUND_LOG2), .LAT_W(LAT_W),
      .ODD_EXTRA(ODD_EXTRA), .CROSS_EXTRA(CROSS_EXTRA)
   ) u_lat (
      .offset(addr_in[BOUND_LOG2-1:0]),
      .wait_cfg(wait_cfg),
      .lat(lat)
   );

   burst_wait_timer #(.LAT_W(LAT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .lat(lat),
      .oe_n(oe_n), .rdy(rdy)
   );

   burst_word_src #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED), .IDLE_WORD(IDLE_WORD)
   ) u_words (
      .clk(clk), .rst_n(rst_n), .load(load), .start_addr(addr_in),
      .step(rdy), .dq(dq)
   );

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rdy && dq == IDLE_WORD)); // R7
   AST_RDY_RISE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> !oe_n); // R9
endmodule

// File: tb/tb_burst_wait_ctrl.sv
`timescale 1ns/1ps
module tb_burst_wait_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv_n;
   logic [7:0]  addr_in;
   logic        oe_n;
   logic [3:0]  wait_cfg;
   logic        rdy;
   logic [15:0] dq;
   int          vectors = 0;
   int          miscompares = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   burst_wait_ctrl dut (
      .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .addr_in(addr_in),
      .oe_n(oe_n), .wait_cfg(wait_cfg), .rdy(rdy), .dq(dq)
   );

   function automatic logic [15:0] exp_word(input int a);
      logic [15:0] x;
      x = 16'(a[7:0]);
      return x ^ (x << 8) ^ 16'hC3A5;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic start(input int a, input int w);
      @(negedge clk);
      adv_n = 1'b0; addr_in = 8'(a); wait_cfg = 4'(w);
      @(negedge clk);
      adv_n = 1'b1;
   endtask

   task automatic run_burst(input string req, input int a, input int lat, input int n);
      for (int k = 0; k < lat; k++) begin
         chk(req, "rdy low during latency", 32'(rdy), 32'd0);
         @(negedge clk);
      end
      for (int j = 0; j < n; j++) begin
         chk(req, "rdy during stream", 32'(rdy), 32'd1);
         chk(req, "stream word", 32'(dq), 32'(exp_word(a + j)));
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1", "rdy after reset", 32'(rdy), 32'd0);
      chk("R1", "dq after reset", 32'(dq), 32'h0000);
   endtask

   task automatic t_even();
      start(8'h20, 3);  run_burst("R2_R6", 8'h20, 3, 5);
      start(8'h10, 0);  run_burst("R2", 8'h10, 0, 2);
      start(8'h0E, 2);  run_burst("R4 offset E", 8'h0E, 2, 3);
   endtask

   task automatic t_odd();
      start(8'h21, 2);  run_burst("R3", 8'h21, 3, 3);
      start(8'h05, 0);  run_burst("R3", 8'h05, 1, 2);
   endtask

   task automatic t_cross();
      start(8'h2F, 1);  run_burst("R4", 8'h2F, 3, 3);
      start(8'hFF, 2);  run_burst("R4_R5 wrap", 8'hFF, 4, 3);
   endtask

   task automatic t_oe_gate();
      oe_n = 1'b1;
      start(8'h34, 2);
      repeat (4) begin
         chk("R7", "rdy with oe high", 32'(rdy), 32'd0);
         chk("R7", "dq idle with oe high", 32'(dq), 32'h0000);
         @(negedge clk);
      end
      oe_n = 1'b0; #1;
      chk("R9", "rdy on late oe fall", 32'(rdy), 32'd1);
      chk("R9", "first word on late oe fall", 32'(dq), 32'(exp_word(8'h34)));
      @(negedge clk);
      chk("R5", "second word", 32'(dq), 32'(exp_word(8'h35)));
      oe_n = 1'b1; #1;
      chk("R7", "rdy drops with oe", 32'(rdy), 32'd0);
      chk("R7", "dq idle with oe", 32'(dq), 32'h0000);
      @(negedge clk);
      oe_n = 1'b0; #1;
      chk("R8", "rdy after burst end", 32'(rdy), 32'd0);
      chk("R8", "dq after burst end", 32'(dq), 32'h0000);
      @(negedge clk);
      chk("R8", "rdy stays low", 32'(rdy), 32'd0);
   endtask

   task automatic t_restart();
      start(8'h40, 0);
      run_burst("R10 first", 8'h40, 0, 2);
      start(8'h51, 1);
      run_burst("R10 restart", 8'h51, 2, 3);
   endtask

   initial begin
      rst_n = 1'b0; adv_n = 1'b1; addr_in = '0; oe_n = 1'b0; wait_cfg = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_even();
      t_odd();
      t_cross();
      t_oe_gate();
      t_restart();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule